// File: doc/BRIEF.md
# Compact 16-bit RISC Core

This block is a small in-order processor core that executes a twelve-instruction, 16-bit instruction set. It has eight 16-bit general-purpose registers. Instruction memory and data memory are separate, and each has a 16-bit byte address. Instructions run one at a time through fetch, decode and execute steps. A load takes one more step to write its result back.

Every instruction word puts its operation code in bits [15:12]. The first register field, rd, is in bits [11:9]. The second register field, rs, is in bits [8:6]. A short immediate is in bits [5:0], a medium immediate in bits [8:0], and a long jump field in bits [11:0]. The operation codes are:

- 0: copy
- 1: add
- 2: subtract
- 3: or
- 4: and
- 5: load-immediate
- 6: add-immediate
- 7: subtract-immediate
- 8: load word
- 9: store word
- 10: branch-if-equal
- 11: jump
- 12 to 15: no-ops

The instruction memory has a synchronous read. Its data appears the cycle after the address. The data memory port has a request strobe and a read/write select. Read data also returns one cycle after the request.

Top module: `tiny16_core`

## Requirements
- R1: While rst_n is low, imem_addr is 0 and dmem_en is 0. After reset the first fetch is from address 0, and all eight registers read as 0.
- R2: Register-register operations compute rd = rd op rs, modulo 2^16. Code 0 copies rs into rd, code 1 adds, code 2 subtracts rs from rd, code 3 is OR and code 4 is AND.
- R3: Codes 5, 6 and 7 use the sign-extended 9-bit immediate in bits [8:0]. Code 5 loads it into rd, code 6 adds it to rd and code 7 subtracts it from rd.
- R4: Load (code 8) and store (code 9) address data memory at rs + sext(bits[5:0]). Memory is little-endian: dmem_wdata[7:0] and dmem_rdata[7:0] belong to the even byte address, and bits [15:8] to the next byte. A load writes rd. A store sends rd.
- R5: Branch (code 10) compares rd with rs. When they are equal, the PC becomes PC+2+(sext(bits[5:0])<<1). Otherwise the PC becomes PC+2. This applies to both forward and backward offsets.
- R6: Jump (code 11) sets the PC to {PC[15:13], bits[11:0], 0}, so it keeps the top three PC bits.
- R7: Codes 12 to 15 only advance the PC by 2. They change no register and make no data-memory access.
- R8: An instruction takes three cycles: fetch, decode and execute. A load takes a fourth cycle to write back. dmem_en is high for exactly one cycle, in the execute cycle of a load or store, and dmem_we is high only for a store.
- R9: imem_addr and, during an access, dmem_addr are always even. Bit 0 of a computed data address is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 16 | Instruction byte address (the PC) |
| imem_rdata | input | 16 | Instruction word, valid one cycle after imem_addr |
| dmem_en | output | 1 | Data-memory access request |
| dmem_we | output | 1 | Read/write select: 1 write, 0 read |
| dmem_addr | output | 16 | Data byte address, even |
| dmem_wdata | output | 16 | Store data, low byte at the even address |
| dmem_rdata | input | 16 | Load data, valid one cycle after a read request |

## Verification
The bench targets the following corner cases:
- Arithmetic that wraps through 0x7FFF/0x8000 and 0xFFFF/0x0000. A core with the wrong carry width or operand order would store the wrong sums and differences.
- Negative 6-bit and 9-bit immediates. A core that zero-extends them would load 0x01FD where 0xFFFD is expected, and would place loads and stores at the wrong addresses.
- Byte order on stores, checked byte by byte. A swapped-lane design would put 0x12 at the even address.
- Taken and untaken compares, and a backward branch that wraps the PC to 0xFFC2. The following jump must keep the top bits 111, and a jump that dropped them would return the fetch address to 0x0020.
- Cycle-by-cycle sampling of the data strobe. An extra or missing pipeline step would shift the load and store strobes away from cycles 5 and 9.
- A check that no-op codes and jumped-over words produce no store.

// File: rtl/tiny16_pkg.sv
// tiny16_pkg: shared sizes, operation codes, sequencer states and the
// decoded-instruction record for the compact 16-bit core.
// Assumes a fixed 16-bit instruction word with the opcode in bits [15:12].
package tiny16_pkg;

    localparam int XLEN  = 16;              // datapath width
    localparam int ILEN  = 16;              // instruction width
    localparam int NREG  = 8;               // architectural registers
    localparam int RIDX  = $clog2(NREG);    // register index width
    localparam int OPW   = 4;               // opcode width
    localparam int J_LEN = 12;              // jump field width

    typedef enum logic [OPW-1:0] {
        OP_MOV  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_OR   = 4'd3,
        OP_AND  = 4'd4,
        OP_MOVI = 4'd5,
        OP_ADDI = 4'd6,
        OP_SUBI = 4'd7,
        OP_LW   = 4'd8,
        OP_SW   = 4'd9,
        OP_BEZ  = 4'd10,
        OP_JMP  = 4'd11
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2,
        ST_LOAD   = 2'd3
    } state_e;

    typedef struct packed {
        logic [OPW-1:0]   op;
        logic [RIDX-1:0]  rd;
        logic [RIDX-1:0]  rs;
        logic [XLEN-1:0]  imm_s;    // sign-extended bits [5:0]
        logic [XLEN-1:0]  imm_m;    // sign-extended bits [8:0]
        logic [J_LEN-1:0] imm_j;    // bits [11:0]
        logic             is_alu;
        logic             is_ld;
        logic             is_st;
        logic             is_br;
        logic             is_jmp;
    } dec_t;

endpackage

// File: rtl/tiny16_decode.sv
// tiny16_decode: splits a latched instruction word into its fields and
// class flags. Purely combinational. Opcodes 12..15 raise no class flag,
// which makes them no-ops in the sequencer.
module tiny16_decode
    import tiny16_pkg::*;
(
    input  logic [ILEN-1:0] insn,
    output dec_t            dec
);

    localparam int S_W = 6;     // short immediate width
    localparam int M_W = 9;     // medium immediate width

    // field extraction and class decode
    always_comb begin
        dec.op     = insn[ILEN-1 -: OPW];
        dec.rd     = insn[11:9];
        dec.rs     = insn[8:6];
        dec.imm_s  = {{(XLEN-S_W){insn[S_W-1]}}, insn[S_W-1:0]};
        dec.imm_m  = {{(XLEN-M_W){insn[M_W-1]}}, insn[M_W-1:0]};
        dec.imm_j  = insn[J_LEN-1:0];
        dec.is_alu = (insn[ILEN-1 -: OPW] <= OP_SUBI);
        dec.is_ld  = (insn[ILEN-1 -: OPW] == OP_LW);
        dec.is_st  = (insn[ILEN-1 -: OPW] == OP_SW);
        dec.is_br  = (insn[ILEN-1 -: OPW] == OP_BEZ);
        dec.is_jmp = (insn[ILEN-1 -: OPW] == OP_JMP);
    end

endmodule

// File: rtl/tiny16_regfile.sv
// tiny16_regfile: general-purpose register array with one write port and
// two combinational read ports. All registers clear on synchronous
// active-low reset. Assumes at most one write per cycle.
module tiny16_regfile #(
    parameter int W  = 16,
    parameter int N  = 8,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] view [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        logic [W-1:0] val_q;

        // hold one register, cleared on reset, loaded when addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (we && (waddr == AW'(g))) begin
                val_q <= wdata;
            end
        end

        assign view[g] = val_q;
    end

    assign rdata_a = view[raddr_a];
    assign rdata_b = view[raddr_b];

endmodule

// File: rtl/tiny16_alu.sv
// tiny16_alu: arithmetic and logic for register-register and
// register-immediate operations. The immediate forms take the
// sign-extended immediate in place of the second register.
module tiny16_alu
    import tiny16_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b_reg,
    input  logic [W-1:0]   imm,
    output logic [W-1:0]   y
);

    logic [W-1:0] b;

    // select the second operand by instruction form
    always_comb begin
        b = ((op == OP_MOVI) || (op == OP_ADDI) || (op == OP_SUBI)) ? imm : b_reg;
    end

    // compute the result, wrapping modulo 2^W
    always_comb begin
        case (op)
            OP_MOV, OP_MOVI: y = b;
            OP_ADD, OP_ADDI: y = a + b;
            OP_SUB, OP_SUBI: y = a - b;
            OP_OR:           y = a | b;
            OP_AND:          y = a & b;
            default:         y = a;
        endcase
    end

endmodule

// File: rtl/tiny16_core.sv
// tiny16_core: multi-cycle in-order core. Each instruction passes through
// fetch, decode and execute; a load adds a write-back cycle. Both memories
// answer one cycle after the request. The PC is updated in the execute
// cycle of every instruction. Assumes XLEN = 16, matching the jump format.
module tiny16_core
    import tiny16_pkg::*;
#(
    parameter int DW = XLEN,
    parameter int NR = NREG
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] imem_addr,
    input  logic [ILEN-1:0] imem_rdata,
    output logic          dmem_en,
    output logic          dmem_we,
    output logic [DW-1:0] dmem_addr,
    output logic [DW-1:0] dmem_wdata,
    input  logic [DW-1:0] dmem_rdata
);

    localparam int RA     = $clog2(NR);
    localparam int KEEP_H = DW - J_LEN - 1;    // PC bits kept by a jump

    state_e          state_q;
    logic [DW-1:0]   pc_q;
    logic [ILEN-1:0] ir_q;
    dec_t            dec;
    logic [DW-1:0]   ra, rb, alu_y, eff_addr;
    logic [DW-1:0]   pc_seq, br_tgt, jmp_tgt, pc_next;
    logic            rf_we;
    logic [DW-1:0]   rf_wdata;

    tiny16_decode u_dec (
        .insn (ir_q),
        .dec  (dec)
    );

    tiny16_regfile #(.W(DW), .N(NR), .AW(RA)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (dec.rd),
        .wdata   (rf_wdata),
        .raddr_a (dec.rd),
        .rdata_a (ra),
        .raddr_b (dec.rs),
        .rdata_b (rb)
    );

    tiny16_alu #(.W(DW)) u_alu (
        .op    (dec.op),
        .a     (ra),
        .b_reg (rb),
        .imm   (dec.imm_m),
        .y     (alu_y)
    );

    // next-PC candidates and selection
    always_comb begin
        pc_seq  = pc_q + DW'(2);
        br_tgt  = pc_seq + (dec.imm_s << 1);
        jmp_tgt = {pc_q[DW-1 -: KEEP_H], dec.imm_j, 1'b0};
        if (dec.is_jmp) begin
            pc_next = jmp_tgt;
        end else if (dec.is_br && (ra == rb)) begin
            pc_next = br_tgt;
        end else begin
            pc_next = pc_seq;
        end
    end

    // register write-back source and enable
    always_comb begin
        rf_we    = ((state_q == ST_EXEC) && dec.is_alu) || (state_q == ST_LOAD);
        rf_wdata = (state_q == ST_LOAD) ? dmem_rdata : alu_y;
    end

    // data-memory request, issued only in the execute cycle
    always_comb begin
        eff_addr   = rb + dec.imm_s;
        dmem_en    = (state_q == ST_EXEC) && (dec.is_ld || dec.is_st);
        dmem_we    = (state_q == ST_EXEC) && dec.is_st;
        dmem_addr  = eff_addr & ~DW'(1);
        dmem_wdata = ra;
        imem_addr  = pc_q;
    end

    // sequencer, PC and instruction register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
            ir_q    <= '0;
        end else begin
            case (state_q)
                ST_FETCH:  state_q <= ST_DECODE;
                ST_DECODE: begin
                    ir_q    <= imem_rdata;
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    pc_q    <= pc_next;
                    state_q <= dec.is_ld ? ST_LOAD : ST_FETCH;
                end
                default:   state_q <= ST_FETCH;
            endcase
        end
    end

endmodule

// File: rtl/tiny16_core_chk.sv
// tiny16_core_chk: temporal checks on the core's ports and sequencer,
// attached to every tiny16_core instance by the bind below.
module tiny16_core_chk
    import tiny16_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] imem_addr,
    input logic        dmem_en,
    input logic        dmem_we,
    input logic [15:0] dmem_addr,
    input state_e      state_q,
    input logic [15:0] ir_q
);

    // R1: a cycle under reset leaves the core idle at address 0
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (imem_addr == 16'h0000 && !dmem_en));

    // R9: fetch and data addresses stay even
    p_even_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_addr[0] == 1'b0) && (!dmem_en || dmem_addr[0] == 1'b0));

    // R8: a data access lasts exactly one cycle
    p_one_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_en |=> !dmem_en);

    // R8: the PC holds for at least the decode cycle after a change
    p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(imem_addr) |=> $stable(imem_addr));

    // R7: a no-op code never reaches data memory
    p_nop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && ir_q[15:12] >= 4'd12) |-> !dmem_en);

    // R4: a read request is followed by the write-back cycle
    p_load_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_en && !dmem_we) |=> (state_q == ST_LOAD));

endmodule

bind tiny16_core tiny16_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .dmem_en   (dmem_en),
    .dmem_we   (dmem_we),
    .dmem_addr (dmem_addr),
    .state_q   (state_q),
    .ir_q      (ir_q)
);

// File: tb/tiny16_core_tb_top.sv
`timescale 1ns/1ps
// tiny16_core_tb_top: drives small programs through the core with
// behavioural instruction and data memories and checks the results that
// the programs store back to data memory.
module tiny16_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_en, dmem_we;

    logic [15:0] imem [256];
    logic [7:0]  dmem [512];
    int          n_run = 0;
    int          n_fail = 0;
    int          acc_cnt = 0;

    always #5 clk = ~clk;

    tiny16_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_en    (dmem_en),
        .dmem_we    (dmem_we),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata)
    );

    // synchronous instruction memory
    always @(posedge clk) imem_rdata <= imem[imem_addr[8:1]];

    // synchronous little-endian data memory
    always @(posedge clk) begin
        if (dmem_en && dmem_we) begin
            dmem[{dmem_addr[8:1], 1'b0}] <= dmem_wdata[7:0];
            dmem[{dmem_addr[8:1], 1'b1}] <= dmem_wdata[15:8];
        end
        dmem_rdata <= {dmem[{dmem_addr[8:1], 1'b1}], dmem[{dmem_addr[8:1], 1'b0}]};
        if (rst_n && dmem_en) acc_cnt <= acc_cnt + 1;
    end

    function automatic logic [15:0] rr(input int op, input int rd, input int rs, input int i6);
        logic [31:0] o = op, d = rd, s = rs, i = i6;
        return {o[3:0], d[2:0], s[2:0], i[5:0]};
    endfunction

    function automatic logic [15:0] ri(input int op, input int rd, input int i9);
        logic [31:0] o = op, d = rd, i = i9;
        return {o[3:0], d[2:0], i[8:0]};
    endfunction

    function automatic logic [15:0] jj(input int t);
        logic [31:0] v = t;
        return {4'd11, v[11:0]};
    endfunction

    function automatic logic [15:0] rd16(input int a);
        return {dmem[a + 1], dmem[a]};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // hold reset and blank both memories
    task automatic begin_prog();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) imem[i] = 16'hC000;
        for (int i = 0; i < 512; i++) dmem[i] = 8'hEE;
    endtask

    // release reset and run n cycles
    task automatic go(input int n);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // R2 vectors: {op, rd value, rs value, expected}
    localparam logic [51:0] VEC [8] = '{
        {4'd0, 16'h1234, 16'hABCD, 16'hABCD},
        {4'd1, 16'h7FFF, 16'h0001, 16'h8000},
        {4'd1, 16'hFFFF, 16'h0002, 16'h0001},
        {4'd2, 16'h0003, 16'h0005, 16'hFFFE},
        {4'd2, 16'h8000, 16'h0001, 16'h7FFF},
        {4'd3, 16'hF0F0, 16'h0F0F, 16'hFFFF},
        {4'd4, 16'hF0F0, 16'h3C3C, 16'h3030},
        {4'd4, 16'hFFFF, 16'h0000, 16'h0000}
    };

    initial begin
        int snap;
        // R2: register-register table
        for (int v = 0; v < 8; v++) begin
            begin_prog();
            {dmem[1], dmem[0]} = VEC[v][47:32];
            {dmem[3], dmem[2]} = VEC[v][31:16];
            imem[0] = rr(8, 1, 0, 0);
            imem[1] = rr(8, 2, 0, 2);
            imem[2] = rr(int'(VEC[v][51:48]), 1, 2, 0);
            imem[3] = rr(9, 1, 0, 4);
            imem[4] = jj(4);
            go(30);
            check("R2 reg-reg op", rd16(4), VEC[v][15:0]);
        end

        // R1: idle during reset, registers cleared
        begin_prog();
        imem[0] = ri(5, 3, 8'h77);
        imem[1] = jj(1);
        go(15);
        @(negedge clk);
        rst_n = 1'b0;
        imem[0] = rr(9, 3, 0, 6);
        imem[1] = jj(1);
        @(negedge clk);
        check("R1 fetch addr in reset", imem_addr, 16'h0000);
        check("R1 no access in reset", {15'd0, dmem_en}, 16'h0000);
        go(15);
        check("R1 registers cleared", rd16(6), 16'h0000);

        // R3: immediates
        begin_prog();
        imem[0] = ri(5, 1, -3);
        imem[1] = rr(9, 1, 0, 8);
        imem[2] = ri(5, 2, 255);
        imem[3] = ri(6, 2, -256);
        imem[4] = rr(9, 2, 0, 10);
        imem[5] = ri(5, 3, 5);
        imem[6] = ri(7, 3, -2);
        imem[7] = rr(9, 3, 0, 12);
        imem[8] = jj(8);
        go(40);
        check("R3 load-imm negative", rd16(8), 16'hFFFD);
        check("R3 add-imm negative", rd16(10), 16'hFFFF);
        check("R3 sub-imm negative", rd16(12), 16'h0007);

        // R4 / R9: offset addressing, byte order, odd address cleared
        begin_prog();
        dmem[32] = 8'h34;
        dmem[33] = 8'h12;
        imem[0] = ri(5, 4, 48);
        imem[1] = rr(8, 1, 4, -16);
        imem[2] = rr(9, 1, 4, 2);
        imem[3] = rr(9, 1, 4, 5);
        imem[4] = jj(4);
        go(30);
        check("R4 low byte at even address", {8'd0, dmem[50]}, 16'h0034);
        check("R4 high byte at next address", {8'd0, dmem[51]}, 16'h0012);
        check("R9 odd address made even", rd16(52), 16'h1234);
        check("R9 odd byte untouched", {8'd0, dmem[54]}, 16'h00EE);

        // R5: taken and untaken compare
        begin_prog();
        imem[0]  = ri(5, 1, 7);
        imem[1]  = ri(5, 2, 7);
        imem[2]  = rr(10, 1, 2, 2);
        imem[3]  = ri(5, 3, 1);
        imem[4]  = ri(5, 3, 2);
        imem[5]  = rr(9, 3, 0, 14);
        imem[6]  = ri(5, 2, 6);
        imem[7]  = rr(10, 1, 2, 1);
        imem[8]  = ri(5, 5, 9);
        imem[9]  = rr(9, 5, 0, 16);
        imem[10] = jj(10);
        go(60);
        check("R5 taken branch skips", rd16(14), 16'h0000);
        check("R5 untaken branch falls through", rd16(16), 16'h0009);

        // R5 / R6: backward wrap then jump keeping top PC bits
        begin_prog();
        imem[0]    = rr(10, 0, 0, -32);
        imem[8'hE1] = jj(12'h010);
        imem[8'h10] = jj(12'h010);
        go(20);
        check("R6 jump keeps PC[15:13] after R5 backward wrap", imem_addr, 16'hE020);

        // R6 / R7: jump over words, no-op codes
        begin_prog();
        imem[0] = jj(3);
        imem[1] = ri(5, 1, 1);
        imem[2] = ri(5, 1, 2);
        imem[3] = 16'hC2FF;
        imem[4] = 16'hF3C5;
        imem[5] = rr(9, 1, 0, 18);
        imem[6] = jj(6);
        snap = acc_cnt;
        go(40);
        check("R6 jumped words not run", rd16(18), 16'h0000);
        check("R7 no-ops make no access", 16'(acc_cnt - snap), 16'h0001);

        // R8: cycle positions of load and store strobes
        begin_prog();
        dmem[0] = 8'h5A;
        dmem[1] = 8'hA5;
        imem[0] = ri(5, 1, 1);
        imem[1] = rr(8, 2, 0, 0);
        imem[2] = rr(9, 2, 0, 2);
        imem[3] = jj(3);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 12; k++) begin
            check($sformatf("R8 strobes cycle %0d", k), {14'd0, dmem_en, dmem_we},
                  {14'd0, (k == 5 || k == 9), (k == 9)});
            @(negedge clk);
        end
        repeat (10) @(negedge clk);
        check("R8 load data stored back", rd16(2), 16'hA55A);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // watchdog: a hung run counts as a failure
    initial begin
        #500us;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule